// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates a 64-bit effective address into a real address. It walks a radix page-table tree that sits in memory. A walk begins with a start pulse that carries the address, the access kind and the privilege level. The block also samples the table register, which holds the process-table base and a 5-bit size field, and the current process ID. The walker first reads a process-table entry. That entry gives the tree size, the width of the root index and the root base. The walker then checks that the address lies inside the tree. After that it reads one directory entry per level until it reaches a leaf. At the leaf it checks the access rights and the reference and change bits, then forms the real address.

Memory is reached through a narrow port. The port carries one 64-bit read request at a time, and a response comes back some cycles later. Each walk ends with a one-cycle done pulse and a 3-bit result code. On success the real address appears beside the pulse. The number of levels is not fixed: each directory entry names the index width of the next level, and the walker reduces a running shift by that width.

Top module: `radix_walker`

## Requirements
- R1: The process-table entry is read from {8'h0, table[55:36], (table[35:12] & ~m) | (pid[31:8] & m), pid[7:0], 4'h0}, where m is a 24-bit mask whose low table[4:0] bits are set.
- R2: When address bit 63 is 1, process ID zero is used to form the process-table entry address.
- R3: Result code 3 (segment) is reported when address bit 63 differs from bit 62, or when any of address bits 61:31 is set above the low S bits. S is the tree size {entry[62:61], entry[7:5]} of the process-table entry. This check wins over the root-width check.
- R4: Result code 2 (bad tree) is reported when the root index width entry[4:0] is below 5, above 16, or above S+19. Otherwise the shift starts at S+19 minus that width.
- R5: At each level the index is (address[61:12] >> shift) truncated to 16 bits. The entry is read from {8'h0, base[55:19], (base[18:3] & ~k) | (index & k), 3'b0}, where k has its low (width) bits set and base is entry[55:8] followed by 8 zero bits. A walk that ends at level L makes L+1 reads.
- R6: A fetched directory entry whose bit 63 is 0 ends the walk with result code 1 (invalid). Bit 62 set marks a leaf.
- R7: For a non-leaf entry, a next width entry[4:0] below 5, above 16, or above the current shift gives result code 2. A width equal to the shift is accepted, and the shift then drops by that width.
- R8: Access kinds are 0 load, 1 store and 2 instruction fetch. The leaf's rights pass only if the request is privileged or leaf bit 3 is 0. A load or store then passes if bit 1 is set, or if bit 2 is set and the access is not a store. A fetch passes if bit 0 is set and bit 5 is clear. A failure gives result code 4.
- R9: The reference/change check passes when leaf bit 8 is set and either bit 7 is set or the access is not a store. A failure gives result code 5, but only when the rights check of R8 passed.
- R10: On success (code 0) the real address is {8'h0, (leaf[55:12] & ~f) | (address[55:12] & f), address[11:0]}, where f has its low (final shift) bits set. On any error the real address is 0.
- R11: At most one read is outstanding. memReq is high for a single cycle, and it is raised again only after memRdValid has answered.
- R12: A start pulse that arrives while a walk is in progress is ignored and does not start a second walk.
- R13: Each walk ends with walkDone high for exactly one cycle, with errCode holding the result. errCode is 0 whenever walkDone is low. After the pulse the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a walk when the walker is idle |
| startEa | input | 64 | Effective address to translate |
| accKind | input | 2 | 0 load, 1 store, 2 instruction fetch |
| privileged | input | 1 | Request comes from privileged state |
| tableReg | input | 64 | Process-table base (bits 55:12) and size (bits 4:0) |
| curPid | input | 32 | Current process ID |
| memReq | output | 1 | One-cycle read request |
| memAddr | output | 64 | Read address, valid with memReq |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 64 | Read data |
| walkDone | output | 1 | One-cycle end-of-walk pulse |
| errCode | output | 3 | 0 ok, 1 invalid, 2 bad tree, 3 segment, 4 permission, 5 reference/change |
| realAddr | output | 64 | Translated real address, valid with walkDone |

## Verification
The checker relies on the memory side answering each request exactly once, after at least one cycle. It also relies on memRdValid staying low when no request is pending. The bench's memory model holds one request at a time and answers it after a latency that cycles from one to three cycles. The model never raises memRdValid on its own. Start pulses are driven freely, including one in the middle of a walk, because the walker must ignore them there.

// File: rtl/rw_pkg.sv
package rw_pkg;
  localparam int EA_W      = 64;
  localparam int PID_W     = 32;
  localparam int MASK_W    = 44;
  localparam int SHIFT_W   = 6;
  localparam int WIDTH_W   = 5;
  localparam int IDX_MIN   = 5;
  localparam int IDX_MAX   = 16;
  localparam int SEG_BIAS  = 19;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_INVALID = 3'd1,
    ERR_BADTREE = 3'd2,
    ERR_SEGMENT = 3'd3,
    ERR_PERM    = 3'd4,
    ERR_RC      = 3'd5
  } walkErr_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } accKind_e;

  typedef struct packed {
    logic capReq;
    logic capPrte;
    logic setSegShift;
    logic capEntry;
    logic stepLevel;
    logic capReal;
    logic selLevel;
  } walkStrobe_t;

  typedef struct packed {
    logic segErr;
    logic segBad;
    logic entValid;
    logic entLeaf;
    logic nextBad;
    logic permOk;
    logic rcOk;
  } walkStatus_t;

  function automatic logic [MASK_W-1:0] lowMask(input logic [SHIFT_W-1:0] n);
    logic [MASK_W-1:0] m;
    for (int i = 0; i < MASK_W; i++) m[i] = (SHIFT_W'(i) < n);
    return m;
  endfunction
endpackage

// File: rtl/rw_datapath.sv
module rw_datapath
  import rw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  walkStrobe_t       strobe,
  input  logic [EA_W-1:0]   reqEa,
  input  logic [1:0]        reqKind,
  input  logic              reqPriv,
  input  logic [EA_W-1:0]   reqTable,
  input  logic [PID_W-1:0]  reqPid,
  input  logic [EA_W-1:0]   rdData,
  output walkStatus_t       status,
  output logic [EA_W-1:0]   memAddr,
  output logic [EA_W-1:0]   realAddr
);
  localparam logic [6:0] BIAS7 = 7'(SEG_BIAS);

  logic [EA_W-1:0]    eaR;
  logic               storeR, fetchR, privR;
  logic [PID_W-1:0]   pidR;
  logic [43:0]        tblBaseR;
  logic [WIDTH_W-1:0] tblSizeR;
  logic [SHIFT_W-1:0] rtsR;
  logic [WIDTH_W-1:0] widthR;
  logic [47:0]        baseHiR;
  logic [SHIFT_W-1:0] shiftR;
  logic [EA_W-1:0]    entryR;
  logic [EA_W-1:0]    realR;

  logic [MASK_W-1:0]  pidMask, rtsMask, idxMask, pageMask;
  logic [6:0]         limit, segShift;
  logic [15:0]        idx, idxMid;
  logic [EA_W-1:0]    prtAddr, lvlAddr, realNext;
  logic [SHIFT_W-1:0] nextShift;
  logic [WIDTH_W-1:0] nextW;

  // process-table entry address
  assign pidMask = lowMask({1'b0, tblSizeR});
  assign prtAddr = {8'h00, tblBaseR[43:24],
                    (tblBaseR[23:0] & ~pidMask[23:0]) | (pidR[31:8] & pidMask[23:0]),
                    pidR[7:0], 4'h0};

  // segment and root-width checks
  assign limit    = {1'b0, rtsR} + BIAS7;
  assign segShift = limit - {2'b00, widthR};
  assign rtsMask  = lowMask(rtsR);
  assign status.segErr = (eaR[63] != eaR[62]) || (|(eaR[61:31] & ~rtsMask[30:0]));
  assign status.segBad = (widthR < WIDTH_W'(IDX_MIN)) || (widthR > WIDTH_W'(IDX_MAX)) ||
                         ({2'b00, widthR} > limit);

  // level lookup address
  assign idx     = 16'(eaR[61:12] >> shiftR);
  assign idxMask = lowMask({1'b0, widthR});
  assign idxMid  = ({baseHiR[10:0], 5'b00000} & ~idxMask[15:0]) | (idx & idxMask[15:0]);
  assign lvlAddr = {8'h00, baseHiR[47:11], idxMid, 3'b000};
  assign memAddr = strobe.selLevel ? lvlAddr : prtAddr;

  // directory entry decode
  assign nextW          = entryR[4:0];
  assign nextShift      = shiftR - {1'b0, nextW};
  assign status.entValid = entryR[63];
  assign status.entLeaf  = entryR[62];
  assign status.nextBad  = (nextW < WIDTH_W'(IDX_MIN)) || (nextW > WIDTH_W'(IDX_MAX)) ||
                           ({1'b0, nextW} > shiftR);

  // leaf rights and reference/change
  logic gateOk, dataOk, execOk;
  assign gateOk = privR || !entryR[3];
  assign dataOk = entryR[1] || (entryR[2] && !storeR);
  assign execOk = entryR[0] && !entryR[5];
  assign status.permOk = gateOk && (fetchR ? execOk : dataOk);
  assign status.rcOk   = entryR[8] && (entryR[7] || !storeR);

  // real address
  assign pageMask = lowMask(shiftR);
  assign realNext = {8'h00, (entryR[55:12] & ~pageMask) | (eaR[55:12] & pageMask), eaR[11:0]};
  assign realAddr = realR;

  logic unusedBits;
  assign unusedBits = ^{reqTable[63:56], reqTable[11:5], entryR[61:56], entryR[6],
                        segShift[6], pidMask[43:24], rtsMask[43:31], idxMask[43:16]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eaR      <= '0;
      storeR   <= 1'b0;
      fetchR   <= 1'b0;
      privR    <= 1'b0;
      pidR     <= '0;
      tblBaseR <= '0;
      tblSizeR <= '0;
      rtsR     <= '0;
      widthR   <= '0;
      baseHiR  <= '0;
      shiftR   <= '0;
      entryR   <= '0;
      realR    <= '0;
    end else begin
      if (strobe.capReq) begin
        eaR      <= reqEa;
        storeR   <= (reqKind == ACC_STORE);
        fetchR   <= (reqKind == ACC_FETCH);
        privR    <= reqPriv;
        pidR     <= reqEa[63] ? '0 : reqPid;
        tblBaseR <= reqTable[55:12];
        tblSizeR <= reqTable[4:0];
        realR    <= '0;
      end
      if (strobe.capPrte) begin
        rtsR    <= {1'b0, rdData[62:61], rdData[7:5]};
        widthR  <= rdData[4:0];
        baseHiR <= rdData[55:8];
      end
      if (strobe.setSegShift) shiftR <= segShift[SHIFT_W-1:0];
      if (strobe.capEntry) entryR <= rdData;
      if (strobe.stepLevel) begin
        widthR  <= nextW;
        shiftR  <= nextShift;
        baseHiR <= entryR[55:8];
      end
      if (strobe.capReal) realR <= realNext;
    end
  end
endmodule

// File: rtl/rw_control.sv
module rw_control
  import rw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        memRdValid,
  input  walkStatus_t status,
  output walkStrobe_t strobe,
  output logic        memReq,
  output logic        walkDone,
  output logic [2:0]  errCode
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRT_REQ, ST_PRT_WAIT, ST_SEG, ST_LVL_REQ, ST_LVL_WAIT, ST_DECODE, ST_DONE
  } walkState_e;

  walkState_e state, nextState;
  walkErr_e   errR, nextErr;

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextErr   = errR;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.capReq = 1'b1;
          nextErr       = ERR_NONE;
          nextState     = ST_PRT_REQ;
        end
      end
      ST_PRT_REQ:  nextState = ST_PRT_WAIT;
      ST_PRT_WAIT: begin
        if (memRdValid) begin
          strobe.capPrte = 1'b1;
          nextState      = ST_SEG;
        end
      end
      ST_SEG: begin
        if (status.segErr) begin
          nextErr   = ERR_SEGMENT;
          nextState = ST_DONE;
        end else if (status.segBad) begin
          nextErr   = ERR_BADTREE;
          nextState = ST_DONE;
        end else begin
          strobe.setSegShift = 1'b1;
          nextState          = ST_LVL_REQ;
        end
      end
      ST_LVL_REQ: begin
        strobe.selLevel = 1'b1;
        nextState       = ST_LVL_WAIT;
      end
      ST_LVL_WAIT: begin
        strobe.selLevel = 1'b1;
        if (memRdValid) begin
          strobe.capEntry = 1'b1;
          nextState       = ST_DECODE;
        end
      end
      ST_DECODE: begin
        strobe.selLevel = 1'b1;
        nextState       = ST_DONE;
        if (!status.entValid) begin
          nextErr = ERR_INVALID;
        end else if (status.entLeaf) begin
          if (!status.permOk)    nextErr = ERR_PERM;
          else if (!status.rcOk) nextErr = ERR_RC;
          else begin
            nextErr        = ERR_NONE;
            strobe.capReal = 1'b1;
          end
        end else if (status.nextBad) begin
          nextErr = ERR_BADTREE;
        end else begin
          strobe.stepLevel = 1'b1;
          nextState        = ST_LVL_REQ;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign memReq   = (state == ST_PRT_REQ) || (state == ST_LVL_REQ);
  assign walkDone = (state == ST_DONE);
  assign errCode  = walkDone ? errR : 3'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      errR  <= ERR_NONE;
    end else begin
      state <= nextState;
      errR  <= nextErr;
    end
  end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import rw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] startEa,
  input  logic [1:0]  accKind,
  input  logic        privileged,
  input  logic [63:0] tableReg,
  input  logic [31:0] curPid,
  output logic        memReq,
  output logic [63:0] memAddr,
  input  logic        memRdValid,
  input  logic [63:0] memRdData,
  output logic        walkDone,
  output logic [2:0]  errCode,
  output logic [63:0] realAddr
);
  walkStrobe_t strobe;
  walkStatus_t status;

  rw_control ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .memRdValid(memRdValid),
    .status    (status),
    .strobe    (strobe),
    .memReq    (memReq),
    .walkDone  (walkDone),
    .errCode   (errCode)
  );

  rw_datapath dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .reqEa   (startEa),
    .reqKind (accKind),
    .reqPriv (privileged),
    .reqTable(tableReg),
    .reqPid  (curPid),
    .rdData  (memRdData),
    .status  (status),
    .memAddr (memAddr),
    .realAddr(realAddr)
  );
endmodule

// File: rtl/rw_checker.sv
module rw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        memReq,
  input logic [63:0] memAddr,
  input logic        memRdValid,
  input logic        walkDone,
  input logic [2:0]  errCode,
  input logic [63:0] realAddr
);
  logic pending;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pending <= 1'b0;
    else if (memReq)     pending <= 1'b1;
    else if (memRdValid) pending <= 1'b0;
  end

  // R11
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n) memReq |-> !pending);
  // R11
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) memReq |=> !memReq);
  // R11
  rsp_expected_chk: assert property (@(posedge clk) disable iff (!rst_n) memRdValid |-> pending);
  // R5
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> (memAddr[2:0] == 3'b000 && memAddr[63:56] == 8'h00));
  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) walkDone |=> !walkDone);
  // R13
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !walkDone |-> errCode == 3'd0);
  // R13
  err_range_chk: assert property (@(posedge clk) disable iff (!rst_n) walkDone |-> errCode <= 3'd5);
  // R10
  err_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walkDone && errCode != 3'd0) |-> realAddr == 64'd0);
  // R11
  no_req_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n) walkDone |-> !memReq && !pending);
endmodule

bind radix_walker rw_checker chkInst (
  .clk       (clk),
  .rst_n     (rst_n),
  .memReq    (memReq),
  .memAddr   (memAddr),
  .memRdValid(memRdValid),
  .walkDone  (walkDone),
  .errCode   (errCode),
  .realAddr  (realAddr)
);

// File: tb/tb_radix_walker.sv
module tb_radix_walker;
  localparam logic [63:0] TB_BASE = 64'h0000_0000_0100_0000;
  localparam logic [63:0] ROOT    = 64'h0000_0000_0030_0000;
  localparam logic [63:0] LV2     = 64'h0000_0000_0040_0000;
  localparam logic [63:0] LV3     = 64'h0000_0000_0050_0000;
  localparam logic [63:0] LV4     = 64'h0000_0000_0060_0000;
  localparam logic [63:0] VL      = 64'hC000_0000_0000_0000;
  localparam logic [63:0] ALLOK   = 64'h0000_0000_0000_0187;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [63:0] startEa = '0, tableReg = TB_BASE | 64'd4, memRdData = '0;
  logic [1:0]  accKind = 2'd0;
  logic        privileged = 1'b1, memRdValid = 1'b0;
  logic [31:0] curPid = '0;
  logic        memReq, walkDone;
  logic [63:0] memAddr, realAddr;
  logic [2:0]  errCode;

  radix_walker dut (
    .clk(clk), .rst_n(rst_n), .start(start), .startEa(startEa), .accKind(accKind),
    .privileged(privileged), .tableReg(tableReg), .curPid(curPid), .memReq(memReq),
    .memAddr(memAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .walkDone(walkDone), .errCode(errCode), .realAddr(realAddr)
  );

  always #2 clk = ~clk;

  logic [63:0] mem [logic [63:0]];
  int total = 0, bad = 0, reqCount = 0, doneCount = 0, lat = 0, seed = 0;
  bit rspBusy = 0, finished = 0;
  logic [63:0] pendAddr = '0, firstAddr = '0;

  // memory model: one request held, latency 1..3
  always @(negedge clk) begin
    memRdValid = 1'b0;
    if (walkDone) doneCount++;
    if (rspBusy) begin
      if (lat <= 1) begin
        memRdValid = 1'b1;
        memRdData  = mem.exists(pendAddr) ? mem[pendAddr] : 64'd0;
        rspBusy    = 0;
      end else lat--;
    end else if (memReq) begin
      rspBusy  = 1;
      pendAddr = memAddr;
      lat      = 1 + (seed % 3);
      seed++;
      if (reqCount == 0) firstAddr = memAddr;
      reqCount++;
    end
  end

  task automatic chkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] makePrte(input int rts, input int w, input logic [63:0] base);
    logic [63:0] e = '0;
    e[62:61] = 2'(rts >> 3);
    e[7:5]   = 3'(rts);
    e[4:0]   = 5'(w);
    e[55:8]  = base[55:8];
    return e;
  endfunction

  function automatic logic [63:0] prtAddrOf(input logic [63:0] ea, input logic [31:0] pid);
    logic [31:0] eff = ea[63] ? 32'd0 : (pid & 32'h0000_0FFF);
    return TB_BASE | (64'(eff) << 4);
  endfunction

  // final shift per leaf level of the standard tree (widths 13,9,9,9; tree size 21)
  function automatic int leafShift(input int lvl);
    return 27 - 9 * (lvl - 1);
  endfunction

  function automatic logic [63:0] expReal(input logic [63:0] ea, input logic [63:0] leaf, input int sh);
    logic [63:0] pm = (64'd1 << (12 + sh)) - 64'd1;
    return ((leaf & ~pm) | (ea & pm)) & 64'h00FF_FFFF_FFFF_FFFF & ~64'h0 & ((leaf & ~pm & 64'h00FF_FFFF_FFFF_F000) | (ea & pm) | ~64'h0);
  endfunction

  task automatic buildStd(input logic [63:0] ea, input int leafLvl, input logic [63:0] leafEnt);
    logic [63:0] bases [4];
    int widths [4];
    int sh;
    bases[0] = ROOT; bases[1] = LV2; bases[2] = LV3; bases[3] = LV4;
    widths[0] = 13; widths[1] = 9; widths[2] = 9; widths[3] = 9;
    mem.delete();
    mem[prtAddrOf(ea, curPid)] = makePrte(21, 13, ROOT);
    sh = 27;
    for (int lv = 0; lv < 4; lv++) begin
      logic [63:0] ix;
      logic [63:0] a;
      ix = (ea >> (12 + sh)) & ((64'd1 << widths[lv]) - 64'd1);
      a  = bases[lv] + ix * 8;
      if (lv + 1 == leafLvl) begin
        mem[a] = leafEnt;
        break;
      end
      mem[a] = 64'h8000_0000_0000_0000 | bases[lv + 1] | 64'(widths[lv + 1]);
      sh = sh - widths[lv + 1];
    end
  endtask

  task automatic doWalk(input logic [63:0] ea, input logic [1:0] kind, input logic priv,
                        output logic [2:0] err, output logic [63:0] ra);
    int cyc = 0;
    reqCount = 0;
    @(negedge clk);
    startEa = ea; accKind = kind; privileged = priv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!walkDone && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    if (!walkDone) chkEq("R13 walk completes", 64'd0, 64'd1);
    err = errCode;
    ra  = realAddr;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0]  e;
    logic [63:0] r;
    logic [63:0] eas [6];
    logic [63:0] page;
    int n0;

    repeat (3) @(negedge clk);
    // R13 reset state
    chkEq("R13 reset walkDone", 64'(walkDone), 64'd0);
    chkEq("R11 reset memReq", 64'(memReq), 64'd0);
    chkEq("R13 reset errCode", 64'(errCode), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R10: walks ending at every level, several addresses
    eas[0] = 64'h0001_2345_6789_ABCD; eas[1] = 64'h000F_FFFF_FFFF_FFFF;
    eas[2] = 64'h0000_0000_0000_0000; eas[3] = 64'h0008_0000_0000_1FFF;
    eas[4] = 64'h0000_7A5C_3E19_0042; eas[5] = 64'hC00F_0000_F000_0F00;
    page   = 64'h0098_7654_3210_F000;
    curPid = 32'h0000_0123;
    for (int i = 0; i < 6; i++) begin
      for (int lv = 1; lv <= 4; lv++) begin
        logic [63:0] pm;
        buildStd(eas[i], lv, VL | page | ALLOK);
        doWalk(eas[i], 2'd0, 1'b1, e, r);
        pm = (64'd1 << (12 + leafShift(lv))) - 64'd1;
        chkEq("R10 ok code", 64'(e), 64'd0);
        chkEq("R10 real address", r, ((page & ~pm) | (eas[i] & pm)) & 64'h00FF_FFFF_FFFF_FFFF);
        chkEq("R5 read count", 64'(reqCount), 64'(lv + 1));
        chkEq("R1 R2 prte address", firstAddr, prtAddrOf(eas[i], curPid));
      end
    end

    // R1: PID bits above the size field are dropped
    curPid = 32'h0000_12A5;
    buildStd(64'h0000_0000_0000_3456, 4, VL | page | ALLOK);
    doWalk(64'h0000_0000_0000_3456, 2'd0, 1'b1, e, r);
    chkEq("R1 prte address pid mix", firstAddr, TB_BASE | 64'h2A50);
    chkEq("R1 walk ok", 64'(e), 64'd0);

    // R2: quadrant with bit 63 set uses PID zero
    buildStd(64'hC000_0000_0000_2000, 4, VL | page | ALLOK);
    doWalk(64'hC000_0000_0000_2000, 2'd0, 1'b1, e, r);
    chkEq("R2 prte address pid zero", firstAddr, TB_BASE);
    chkEq("R2 real", r, page | 64'h000);
    curPid = 32'h0;

    // R3: segment errors
    buildStd(64'h0010_0000_0000_0000, 4, VL | page | ALLOK);
    doWalk(64'h0010_0000_0000_0000, 2'd0, 1'b1, e, r);
    chkEq("R3 bit above tree size", 64'(e), 64'd3);
    chkEq("R3 single read", 64'(reqCount), 64'd1);
    chkEq("R10 zero on error", r, 64'd0);
    buildStd(64'h2000_0000_0000_0000, 4, VL | page | ALLOK);
    doWalk(64'h2000_0000_0000_0000, 2'd0, 1'b1, e, r);
    chkEq("R3 bit 61 set", 64'(e), 64'd3);
    buildStd(64'h4000_0000_0000_0000, 4, VL | page | ALLOK);
    doWalk(64'h4000_0000_0000_0000, 2'd0, 1'b1, e, r);
    chkEq("R3 bits 63/62 differ", 64'(e), 64'd3);

    // R4: root width out of range, and segment priority
    mem.delete();
    mem[TB_BASE] = makePrte(21, 4, ROOT);
    doWalk(64'h1000, 2'd0, 1'b1, e, r);
    chkEq("R4 root width 4", 64'(e), 64'd2);
    mem[TB_BASE] = makePrte(21, 17, ROOT);
    doWalk(64'h1000, 2'd0, 1'b1, e, r);
    chkEq("R4 root width 17", 64'(e), 64'd2);
    chkEq("R4 single read", 64'(reqCount), 64'd1);
    doWalk(64'h8000_0000_0000_1000, 2'd0, 1'b1, e, r);
    chkEq("R3 segment wins over R4", 64'(e), 64'd3);

    // R7: next width above shift, and equal to shift
    mem.delete();
    mem[TB_BASE] = makePrte(0, 13, ROOT);
    mem[ROOT] = 64'h8000_0000_0000_0000 | LV2 | 64'd9;
    doWalk(64'h0000_0000_0000_5123, 2'd0, 1'b1, e, r);
    chkEq("R7 width above shift", 64'(e), 64'd2);
    mem[ROOT] = 64'h8000_0000_0000_0000 | LV2 | 64'd6;
    mem[LV2 + 5 * 8] = VL | 64'h0000_0000_7700_0000 | ALLOK;
    doWalk(64'h0000_0000_0000_5123, 2'd0, 1'b1, e, r);
    chkEq("R7 width equal shift code", 64'(e), 64'd0);
    chkEq("R7 width equal shift real", r, 64'h0000_0000_7700_0123);
    mem[ROOT] = 64'h8000_0000_0000_0000 | LV2 | 64'd4;
    doWalk(64'h0000_0000_0000_5123, 2'd0, 1'b1, e, r);
    chkEq("R7 width below 5", 64'(e), 64'd2);

    // R6: invalid entries at root and leaf
    buildStd(64'h0001_2345_6789_ABCD, 1, 64'd0);
    doWalk(64'h0001_2345_6789_ABCD, 2'd0, 1'b1, e, r);
    chkEq("R6 invalid root", 64'(e), 64'd1);
    chkEq("R6 read count", 64'(reqCount), 64'd2);
    buildStd(64'h0001_2345_6789_ABCD, 4, 64'h4000_0000_0000_0000 | page | ALLOK);
    doWalk(64'h0001_2345_6789_ABCD, 2'd0, 1'b1, e, r);
    chkEq("R6 invalid leaf", 64'(e), 64'd1);

    // R8 R9: sweep of rights bits, access kinds and privilege
    for (int k = 0; k < 3; k++) begin
      for (int p = 0; p < 2; p++) begin
        for (int m = 0; m < 128; m++) begin
          logic [6:0]  mb;
          logic [63:0] ent;
          bit pok, rok, st, fe;
          logic [2:0] ex;
          mb = 7'(m);
          ent = VL | page;
          ent[0] = mb[0]; ent[1] = mb[1]; ent[2] = mb[2]; ent[3] = mb[3];
          ent[5] = mb[4]; ent[7] = mb[5]; ent[8] = mb[6];
          st  = (k == 1);
          fe  = (k == 2);
          pok = (p == 1 || !mb[3]) && (fe ? (mb[0] && !mb[4]) : (mb[1] || (mb[2] && !st)));
          rok = mb[6] && (mb[5] || !st);
          ex  = !pok ? 3'd4 : (!rok ? 3'd5 : 3'd0);
          buildStd(64'h0001_2345_6789_ABCD, 4, ent);
          doWalk(64'h0001_2345_6789_ABCD, 2'(k), 1'(p), e, r);
          chkEq("R8 R9 result code", 64'(e), 64'(ex));
          chkEq("R10 real after rights", r, (ex == 3'd0) ? (page | 64'hBCD) : 64'd0);
        end
      end
    end

    // R12: start during a walk is ignored
    buildStd(64'h0000_0000_0000_1ABC, 4, VL | page | ALLOK);
    n0 = doneCount;
    @(negedge clk);
    startEa = 64'h0000_0000_0000_1ABC; accKind = 2'd0; privileged = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    startEa = 64'h0000_0000_0000_2DEF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int cyc = 0;
      while (!walkDone && cyc < 400) begin
        @(negedge clk);
        cyc++;
      end
    end
    chkEq("R12 first walk real", realAddr, page | 64'hABC);
    repeat (40) @(negedge clk);
    chkEq("R12 one done pulse", 64'(doneCount - n0), 64'd1);
    chkEq("R13 idle after done", 64'(walkDone), 64'd0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule